// File: doc/BRIEF.md
# Instruction Count Trigger

This block is one debug trigger that counts retired instructions. Software loads a remaining-instruction count and a set of privilege-mode enables into the trigger's control word. Each instruction that retires in an enabled mode lowers the count by one. When the count drops from one to zero, the block raises a one-cycle breakpoint request toward the hart's exception logic.

The count lives in the control word itself, so any read of that word returns the instructions still to go. A count of zero leaves the trigger idle until software writes a new value. The hart reports each retirement on a plain strobe, together with its privilege level and whether it is running virtualised. The block has no valid/ready interface: every input is sampled on each clock edge and cannot be stalled, and the breakpoint request is a pulse, not a held handshake.

Top module: `icnt_trigger`

## Requirements
- R1: After reset the control word (select code 0) reads with the type value 3 in bits 31:28 and every other bit zero, and `fire_o` is low.
- R2: A write with select code 0 stores the count from bits 23:10 and the enables U (bit 6), S (bit 7), M (bit 9), VS (bit 25) and VU (bit 26). All other bits, including action (5:0), pending (8) and hit (24), read as zero, and bits 31:28 keep reading 3.
- R3: A retire in an enabled mode with a non-zero count lowers the count by one at that edge. When not virtualised, level 0 uses U, level 1 uses S and level 3 uses M. When virtualised, level 0 uses VU and level 1 uses VS.
- R4: A retire in a mode whose enable is clear leaves the count unchanged. Level 2 is never enabled, and neither is level 3 while virtualised.
- R5: With a count of zero, retires leave the count at zero and raise no request.
- R6: A retire that moves the count from one to zero sets `fire_o` high for exactly the one cycle after that edge. In that same cycle the count field reads zero.
- R7: Once the count is zero it stays zero until software writes the control word again.
- R8: A control-word write in the same cycle as a counted retire stores the written value, with no decrement and no request.
- R9: Writes with select codes 1 and 2 leave the control word unchanged. Reads with select codes 1, 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Hart is running virtualised |
| sel_i | input | 2 | Register select for reads and writes (0 control, 1 and 2 absent data words) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | XLEN | Write data |
| rd_data_o | output | XLEN | Read data of the selected register |
| fire_o | output | 1 | Breakpoint exception request, one cycle |

## Verification
The bench builds the block with its defaults: a 32-bit word and a 14-bit count at bit 10. With these values, a write of all ones loads the largest count, 16383, which tests the top of the count range, and the packed field positions tested at the ports are exactly the ones a decoding neighbour relies on. Short counts of one to three bring the one-to-zero transition and the write-versus-retire collision into a few cycles. Both the real and the virtualised enable sets are exercised at every privilege level.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int unsigned BIT_EN_U  = 6;
  localparam int unsigned BIT_EN_S  = 7;
  localparam int unsigned BIT_EN_M  = 9;
  localparam int unsigned BIT_EN_VS = 25;
  localparam int unsigned BIT_EN_VU = 26;
  localparam logic [3:0]  KIND_ICNT = 4'd3;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    PICK_CTRL  = 2'd0,
    PICK_DATA2 = 2'd1,
    PICK_DATA3 = 2'd2,
    PICK_NONE  = 2'd3
  } pick_e;

  typedef struct packed {
    logic vu;
    logic vs;
    logic m;
    logic s;
    logic u;
  } mode_en_t;
endpackage

// File: rtl/icnt_mode_gate.sv
module icnt_mode_gate
  import icnt_pkg::*;
(
  input  mode_en_t   en_i,
  input  logic [1:0] lvl_i,
  input  logic       virt_i,
  output logic       active_o
);
  always_comb begin
    active_o = 1'b0;
    if (virt_i) begin
      case (lvl_e'(lvl_i))
        LVL_USER:  active_o = en_i.vu;
        LVL_SUPER: active_o = en_i.vs;
        default:   active_o = 1'b0;
      endcase
    end else begin
      case (lvl_e'(lvl_i))
        LVL_USER:  active_o = en_i.u;
        LVL_SUPER: active_o = en_i.s;
        LVL_MACH:  active_o = en_i.m;
        default:   active_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      fire_q <= 1'b0;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_q  <= cnt_q - ONE;
      fire_q <= (cnt_q == ONE);
    end else begin
      fire_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign fire_o  = fire_q;
endmodule

// File: rtl/icnt_enable_reg.sv
module icnt_enable_reg
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output mode_en_t        en_o
);
  mode_en_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q.u  <= wdata_i[BIT_EN_U];
      en_q.s  <= wdata_i[BIT_EN_S];
      en_q.m  <= wdata_i[BIT_EN_M];
      en_q.vs <= wdata_i[BIT_EN_VS];
      en_q.vu <= wdata_i[BIT_EN_VU];
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/icnt_read_view.sv
module icnt_read_view
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned CNT_LSB = 10
) (
  input  logic [1:0]       pick_i,
  input  mode_en_t         en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [XLEN-1:0]  rdata_o
);
  localparam int unsigned KIND_LSB = XLEN - 4;

  logic [XLEN-1:0] ctrl_word;

  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[KIND_LSB +: 4]       = KIND_ICNT;
    ctrl_word[CNT_LSB +: CNT_W]    = count_i;
    ctrl_word[BIT_EN_U]            = en_i.u;
    ctrl_word[BIT_EN_S]            = en_i.s;
    ctrl_word[BIT_EN_M]            = en_i.m;
    ctrl_word[BIT_EN_VS]           = en_i.vs;
    ctrl_word[BIT_EN_VU]           = en_i.vu;
  end

  always_comb begin
    case (pick_e'(pick_i))
      PICK_CTRL: rdata_o = ctrl_word;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned CNT_LSB = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic [1:0]      sel_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            fire_o
);
  logic             wr_ctrl;
  logic             active_w;
  logic [CNT_W-1:0] count_w;
  mode_en_t         en_w;

  assign wr_ctrl = wr_en_i && (pick_e'(sel_i) == PICK_CTRL);

  icnt_enable_reg #(.XLEN(XLEN)) en_reg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_ctrl),
    .wdata_i (wr_data_i),
    .en_o    (en_w)
  );

  icnt_mode_gate gate_i (
    .en_i     (en_w),
    .lvl_i    (priv_i),
    .virt_i   (virt_i),
    .active_o (active_w)
  );

  icnt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_ctrl),
    .load_val_i (wr_data_i[CNT_LSB +: CNT_W]),
    .step_i     (retire_i && active_w),
    .count_o    (count_w),
    .fire_o     (fire_o)
  );

  icnt_read_view #(.XLEN(XLEN), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)) view_i (
    .pick_i  (sel_i),
    .en_i    (en_w),
    .count_i (count_w),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/icnt_trigger_chk.sv
module icnt_trigger_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned CNT_LSB = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire_i,
  input logic [1:0]       sel_i,
  input logic             wr_en_i,
  input logic [XLEN-1:0]  wr_data_i,
  input logic             fire_o,
  input logic [CNT_W-1:0] count_i,
  input logic             active_i
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && (sel_i == 2'd0);

  // R6
  fire_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (count_i == '0) && ($past(count_i) == CNT_W'(1)));

  // R6
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  // R5
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) && !wr_ctrl |=> (count_i == '0) && !fire_o);

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (count_i == $past(wr_data_i[CNT_LSB +: CNT_W])) && !fire_o);

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl && retire_i && active_i && (count_i != '0)
      |=> count_i == $past(count_i) - CNT_W'(1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl && !(retire_i && active_i) |=> $stable(count_i));
endmodule

bind icnt_trigger icnt_trigger_chk #(
  .XLEN(XLEN), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .retire_i  (retire_i),
  .sel_i     (sel_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .fire_o    (fire_o),
  .count_i   (count_w),
  .active_i  (active_w)
);

// File: tb/icnt_trigger_tb_top.sv
module icnt_trigger_tb_top;
  localparam int XLEN = 32;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sel;
    logic [31:0] wdata;
    logic        ret;
    logic [1:0]  lvl;
    logic        virt;
    logic [13:0] exp_cnt;
    logic        exp_fire;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 32'h0000_0E40, 1'b0, 2'd0, 1'b0, 14'd3, 1'b0}, // R2 load 3, U+M
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd2, 1'b0}, // R3 M
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b0, 14'd2, 1'b0}, // R4 S off
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b0, 14'd1, 1'b0}, // R3 U
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b1, 14'd1, 1'b0}, // R4 VU off
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd2, 1'b0, 14'd1, 1'b0}, // R4 level 2
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd0, 1'b1}, // R6 fire
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd0, 1'b0}, // R5 R7 idle
    '{1'b1, 2'd0, 32'h0200_0800, 1'b1, 2'd1, 1'b1, 14'd2, 1'b0}, // R8 load 2 VS
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b1, 14'd1, 1'b0}, // R3 VS
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b0, 14'd1, 1'b0}, // R4 S off
    '{1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 14'd1, 1'b0}, // R9
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 14'd1, 1'b0}, // R9
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b1, 14'd0, 1'b1}, // R6 fire
    '{1'b1, 2'd0, 32'h0200_0400, 1'b1, 2'd1, 1'b1, 14'd1, 1'b0}, // R8 load 1
    '{1'b0, 2'd0, 32'h0,         1'b0, 2'd1, 1'b1, 14'd1, 1'b0}, // R4 no retire
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b1, 14'd0, 1'b1}, // R6 fire
    '{1'b0, 2'd0, 32'h0,         1'b0, 2'd1, 1'b1, 14'd0, 1'b0}  // R6 single pulse
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            retire_i = 1'b0;
  logic [1:0]      priv_i = 2'd0;
  logic            virt_i = 1'b0;
  logic [1:0]      sel_i = 2'd0;
  logic            wr_en_i = 1'b0;
  logic [XLEN-1:0] wr_data_i = '0;
  logic [XLEN-1:0] rd_data_o;
  logic            fire_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  icnt_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i),
    .virt_i(virt_i), .sel_i(sel_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .fire_o(fire_o)
  );

  task automatic check_word(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] sel, input logic [31:0] wd,
                       input logic ret, input logic [1:0] lvl, input logic vt);
    @(negedge clk);
    wr_en_i = wr; sel_i = sel; wr_data_i = wd;
    retire_i = ret; priv_i = lvl; virt_i = vt;
    @(posedge clk);
    #1;
    wr_en_i = 1'b0; sel_i = 2'd0; wr_data_i = '0; retire_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check_word("R1 ctrl", rd_data_o, 32'h3000_0000);
    check_word("R1 fire", {31'd0, fire_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 write all ones: only count, enables and constant type remain
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0);
    check_word("R2 full word", rd_data_o, 32'h36FF_FEC0);
    // R3 decrement from the top of the range
    drive(1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 1'b0);
    check_word("R3 max count", {18'd0, rd_data_o[23:10]}, 32'h0000_3FFE);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].sel, VEC[i].wdata, VEC[i].ret, VEC[i].lvl, VEC[i].virt);
      checks++;
      if (rd_data_o[23:10] !== VEC[i].exp_cnt || fire_o !== VEC[i].exp_fire) begin
        errors++;
        $display("FAIL row %0d (R2-R9 table): actual cnt %0d fire %0b expected cnt %0d fire %0b",
                 i, rd_data_o[23:10], fire_o, VEC[i].exp_cnt, VEC[i].exp_fire);
      end
    end

    // R9 absent data words read zero
    sel_i = 2'd1; #1;
    check_word("R9 sel1 read", rd_data_o, 32'h0);
    sel_i = 2'd2; #1;
    check_word("R9 sel2 read", rd_data_o, 32'h0);
    sel_i = 2'd3; #1;
    check_word("R9 sel3 read", rd_data_o, 32'h0);
    sel_i = 2'd0; #1;
    // R7 zero holds across many enabled retires
    for (int k = 0; k < 5; k++) drive(1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 1'b1);
    check_word("R7 held zero", {18'd0, rd_data_o[23:10]}, 32'd0);
    check_word("R5 no fire", {31'd0, fire_o}, 32'd0);

    // R1 reset mid-run clears state
    drive(1'b1, 2'd0, 32'h0000_1A40, 1'b0, 2'd0, 1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    check_word("R1 reset again", rd_data_o, 32'h3000_0000);
    @(negedge clk); rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule